// File: doc/BRIEF.md
# Calibrated Timebase Divider Chain

This block turns a 32,768 Hz oscillator enable into a one-second tick, with a signed digital rate trim applied at the stage that divides by 256. Software sets a five-bit magnitude N and a sign. A 64-minute schedule, advanced by a minute-rollover pulse from the calendar logic, picks which minutes receive one corrected second. The corrected second is either lengthened (some oscillator enables are ignored) or shortened (some enables count twice at the divide-by-256 input).

The block also owns the 8-bit control byte, which holds the output-level bit, the test-mode bit, the sign and N. It drives a square-wave test tap taken before the correction and a pin that shows either that tap or the output-level bit. A write to the control byte clears the chain, and so does the strobe that marks a write to the seconds register. An oscillator-disable level stops all counting.

Position 0 of the schedule is entered only through a rollover from position 63. The first minute after reset is therefore never corrected.

Top module: `cal_timebase`

## Requirements
- R1: After reset the control byte holds output-level 1 and test-mode, sign and N all 0. The pin is high, and `sec_tick` and `tap512` are low.
- R2: With no correction, `sec_tick` pulses for one clock once every 2^(PRE_W+SEC_W) enabled oscillator ticks (32,768 by default). The pulse appears in the cycle after the edge that takes the last tick.
- R3: While `osc_off` is high, oscillator enables are ignored. Neither `sec_tick` nor `tap512` changes.
- R4: A cycle with `sec_wr` or `ctl_wr` high clears the divider and the tap, and cancels any pending correction. The next `sec_tick` then comes a full uncorrected second later.
- R5: Each `minute_roll` pulse advances a 6-bit schedule position, which wraps from 63 to 0. The second that starts with that pulse is corrected only if the new position is below 2·N. Rollover has priority over an end of second in the same cycle.
- R6: With sign 0, the first 2^(PRE_W-1) enabled ticks (128 by default) of a corrected second are ignored. The second is lengthened by that many ticks.
- R7: With sign 1, the first 2^PRE_W enabled ticks (256 by default) of a corrected second each advance the divide-by-256 stage by two. The second is shortened by that many ticks.
- R8: `tap512` toggles after every 2^TAP_W enabled raw ticks (32 by default), whatever the calibration setting, including during a corrected second.
- R9: With the test-mode bit at 1 the pin follows `tap512`. With it at 0 the pin shows the output-level bit.
- R10: The control byte layout is bit 7 output level, bit 6 test mode, bit 5 sign (1 = faster), and bits 4:0 N. A write takes effect in the cycle after `ctl_wr`.
- R11: With N = 0 no second is ever corrected. With N = 31, positions 0 to 61 are corrected and positions 62 and 63 are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| osc_off | input | 1 | Oscillator disabled; chain holds |
| sec_wr | input | 1 | Seconds register written; clears chain |
| ctl_wr | input | 1 | Control byte write strobe; clears chain |
| ctl_din | input | 8 | Control byte write data |
| minute_roll | input | 1 | Minute rollover pulse from the calendar |
| sec_tick | output | 1 | One-second tick pulse |
| tap512 | output | 1 | Uncorrected square-wave test tap |
| ft_pin | output | 1 | Test tap or output-level bit |

## Verification
The checker watches, on every cycle, the properties that are local in time. These are the single-cycle width of the tick, the frozen tap and absent tick while the oscillator is off, the clear after either write strobe, the reset values, and the output-level bit reaching the pin. It also checks the wrap of the schedule position and that N = 0 never opens a correction. How long a corrected second lasts, how a rollover interacts with the schedule boundary at 2·N, and whether the tap keeps its rate during blanking or insertion can only be shown by the bench. The bench runs whole seconds against its reference model and measures tick spacing at chosen schedule positions.

// File: rtl/cal_timebase_pkg.sv
package cal_timebase_pkg;

  localparam int CAL_W = 5;

  typedef enum logic [1:0] {
    ADJ_NONE   = 2'd0,
    ADJ_BLANK  = 2'd1,
    ADJ_INSERT = 2'd2
  } adj_e;

  typedef struct packed {
    logic             out_lvl;
    logic             ft;
    logic             sgn;
    logic [CAL_W-1:0] mag;
  } ctl_t;

  localparam ctl_t CTL_RST = '{out_lvl: 1'b1, ft: 1'b0, sgn: 1'b0, mag: '0};

endpackage

// File: rtl/ctb_ctl.sv
module ctb_ctl
  import cal_timebase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] din,
  output ctl_t       ctl
);

  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) ctl_d = ctl_t'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/ctb_sched.sv
module ctb_sched
  import cal_timebase_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CYC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             roll,
  input  logic             wrap,
  input  logic             tick,
  input  logic [CAL_W-1:0] mag,
  input  logic             positive,
  output adj_e             adj,
  output logic [CYC_W-1:0] pos
);

  localparam int INS_N = 1 << PRE_W;
  localparam int BLK_N = INS_N / 2;

  logic [CYC_W-1:0] pos_q, pos_d;
  logic             win_q, win_d;
  logic [PRE_W:0]   cnt_q, cnt_d;
  logic [PRE_W:0]   lim;
  logic [CYC_W:0]   span;
  logic             busy;

  always_comb begin
    lim   = positive ? (PRE_W+1)'(INS_N) : (PRE_W+1)'(BLK_N);
    busy  = win_q && (cnt_q < lim);
    adj   = busy ? (positive ? ADJ_INSERT : ADJ_BLANK) : ADJ_NONE;
    span  = (CYC_W+1)'({mag, 1'b0});
    pos_d = roll ? pos_q + 1'b1 : pos_q;
    win_d = win_q;
    cnt_d = cnt_q;
    if (clr) begin
      win_d = 1'b0;
      cnt_d = '0;
    end else if (roll) begin
      win_d = ({1'b0, pos_d} < span);
      cnt_d = '0;
    end else if (wrap) begin
      win_d = 1'b0;
    end else if (busy && tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      win_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pos_q <= pos_d;
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/ctb_divider.sv
module ctb_divider
  import cal_timebase_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int SEC_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  adj_e adj,
  output logic wrap,
  output logic sec_tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             stk_q, stk_d;
  logic [1:0]       step;
  logic [PRE_W:0]   sum;
  logic             carry;

  always_comb begin
    unique case (adj)
      ADJ_BLANK:  step = 2'd0;
      ADJ_INSERT: step = 2'd2;
      default:    step = 2'd1;
    endcase
    sum   = {1'b0, pre_q} + {{(PRE_W-1){1'b0}}, step};
    carry = tick && sum[PRE_W];
    wrap  = carry && (&sec_q);
    pre_d = pre_q;
    sec_d = sec_q;
    if (clr) begin
      pre_d = '0;
      sec_d = '0;
    end else if (tick) begin
      pre_d = sum[PRE_W-1:0];
      if (carry) sec_d = sec_q + 1'b1;
    end
    stk_d = !clr && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= '0;
      stk_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      sec_q <= sec_d;
      stk_q <= stk_d;
    end
  end

  assign sec_tick = stk_q;

endmodule

// File: rtl/ctb_tap.sv
module ctb_tap #(
  parameter int TAP_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic tap
);

  logic [TAP_W-1:0] cnt_q, cnt_d;
  logic             tap_q, tap_d;

  always_comb begin
    cnt_d = cnt_q;
    tap_d = tap_q;
    if (clr) begin
      cnt_d = '0;
      tap_d = 1'b0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      if (&cnt_q) tap_d = ~tap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tap_q <= tap_d;
    end
  end

  assign tap = tap_q;

endmodule

// File: rtl/cal_timebase.sv
module cal_timebase
  import cal_timebase_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int SEC_W = 7,
  parameter int TAP_W = 5,
  parameter int CYC_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       osc_off,
  input  logic       sec_wr,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_din,
  input  logic       minute_roll,
  output logic       sec_tick,
  output logic       tap512,
  output logic       ft_pin
);

  ctl_t             ctl_q;
  adj_e             adj_sel;
  logic [CYC_W-1:0] pos_w;
  logic             tick_en;
  logic             chain_clr;
  logic             sec_wrap;

  assign tick_en   = osc_tick && !osc_off;
  assign chain_clr = sec_wr || ctl_wr;

  ctb_ctl u_ctl (
    .clk (clk),
    .rst_n (rst_n),
    .wr (ctl_wr),
    .din (ctl_din),
    .ctl (ctl_q)
  );

  ctb_sched #(.PRE_W(PRE_W), .CYC_W(CYC_W)) u_sched (
    .clk (clk),
    .rst_n (rst_n),
    .clr (chain_clr),
    .roll (minute_roll),
    .wrap (sec_wrap),
    .tick (tick_en),
    .mag (ctl_q.mag),
    .positive (ctl_q.sgn),
    .adj (adj_sel),
    .pos (pos_w)
  );

  ctb_divider #(.PRE_W(PRE_W), .SEC_W(SEC_W)) u_div (
    .clk (clk),
    .rst_n (rst_n),
    .clr (chain_clr),
    .tick (tick_en),
    .adj (adj_sel),
    .wrap (sec_wrap),
    .sec_tick (sec_tick)
  );

  ctb_tap #(.TAP_W(TAP_W)) u_tap (
    .clk (clk),
    .rst_n (rst_n),
    .clr (chain_clr),
    .tick (tick_en),
    .tap (tap512)
  );

  assign ft_pin = ctl_q.ft ? tap512 : ctl_q.out_lvl;

endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int CYC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_off,
  input logic             sec_wr,
  input logic             ctl_wr,
  input logic [7:0]       ctl_din,
  input logic             minute_roll,
  input logic             sec_tick,
  input logic             tap512,
  input logic             ft_pin,
  input logic [1:0]       adj,
  input logic [4:0]       mag,
  input logic [CYC_W-1:0] pos
);

  a_r1_reset_vals: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ft_pin && !sec_tick && !tap512));

  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  a_r3_tap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !sec_wr && !ctl_wr) |=> $stable(tap512));

  a_r3_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |=> !sec_tick);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wr || ctl_wr) |=> (!sec_tick && !tap512));

  a_r10_out_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_din[6]) |=> (ft_pin == $past(ctl_din[7])));

  a_r5_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (minute_roll && (&pos)) |=> (pos == '0));

  a_r11_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (mag == 5'd0) |-> (adj == 2'd0));

endmodule

bind cal_timebase ctb_checker #(.CYC_W(CYC_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .osc_off (osc_off),
  .sec_wr (sec_wr),
  .ctl_wr (ctl_wr),
  .ctl_din (ctl_din),
  .minute_roll (minute_roll),
  .sec_tick (sec_tick),
  .tap512 (tap512),
  .ft_pin (ft_pin),
  .adj (adj_sel),
  .mag (ctl_q.mag),
  .pos (pos_w)
);

// File: tb/sim_cal_timebase.sv
module sim_cal_timebase;

  localparam int PW   = 4;
  localparam int SW   = 3;
  localparam int TW   = 2;
  localparam int P    = 1 << (PW + SW);
  localparam int BLK  = 1 << (PW - 1);
  localparam int INS  = 1 << PW;
  localparam int TAPN = 1 << TW;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_tick, osc_off, sec_wr, ctl_wr, minute_roll;
  logic [7:0] ctl_din;
  logic       sec_tick, tap512, ft_pin;

  int  checks = 0;
  int  fails  = 0;
  int  par    = 0;
  int  bpos   = 0;
  bit  sparse = 1'b0;

  int ph, mpos, mwin, madj, mtc, mtap, msec, mout, mft, ms, mcal;

  always #4 clk = ~clk;

  cal_timebase #(.PRE_W(PW), .SEC_W(SW), .TAP_W(TW)) u0 (
    .clk (clk),
    .rst_n (rst_n),
    .osc_tick (osc_tick),
    .osc_off (osc_off),
    .sec_wr (sec_wr),
    .ctl_wr (ctl_wr),
    .ctl_din (ctl_din),
    .minute_roll (minute_roll),
    .sec_tick (sec_tick),
    .tap512 (tap512),
    .ft_pin (ft_pin)
  );

  // behavioural reference: one phase integer per second
  always @(posedge clk) begin : model
    int lim, step;
    bit tk, cr, clr, wrp;
    if (!rst_n) begin
      ph = 0; mpos = 0; mwin = 0; madj = 0; mtc = 0; mtap = 0; msec = 0;
      mout = 1; mft = 0; ms = 0; mcal = 0;
    end else begin
      clr  = sec_wr || ctl_wr;
      tk   = osc_tick && !osc_off;
      lim  = ms ? INS : BLK;
      cr   = (mwin != 0) && (madj < lim);
      step = cr ? (ms ? 2 : 0) : 1;
      wrp  = 1'b0;
      if (clr) begin
        ph = 0; mtc = 0; mtap = 0;
      end else if (tk) begin
        ph = ph + step;
        if (ph >= P) begin ph = ph - P; wrp = 1'b1; end
        mtc = mtc + 1;
        if (mtc == TAPN) begin mtc = 0; mtap = 1 - mtap; end
      end
      msec = wrp ? 1 : 0;
      if (minute_roll) mpos = (mpos + 1) % 64;
      if (clr) begin mwin = 0; madj = 0; end
      else if (minute_roll) begin mwin = (mpos < 2 * mcal) ? 1 : 0; madj = 0; end
      else if (wrp) mwin = 0;
      else if (cr && tk) madj = madj + 1;
      if (ctl_wr) begin
        mout = int'(ctl_din[7]); mft = int'(ctl_din[6]);
        ms = int'(ctl_din[5]); mcal = int'(ctl_din[4:0]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    int e;
    @(negedge clk);
    if (rst_n) begin
      e = (msec << 2) | (mtap << 1) | (mft != 0 ? mtap : mout);
      chk({sec_tick, tap512, ft_pin} == 3'(e), "R2 R8 R9 per-cycle model",
          int'({sec_tick, tap512, ft_pin}), e);
    end
    sec_wr = 1'b0; ctl_wr = 1'b0; minute_roll = 1'b0;
    par++;
    osc_tick = sparse ? par[0] : 1'b1;
  endtask

  task automatic meas(output int n);
    n = 0;
    do begin cyc(); n++; end while (sec_tick !== 1'b1 && n < 700);
  endtask

  task automatic roll_once();
    cyc();
    minute_roll = 1'b1;
    bpos = (bpos + 1) % 64;
  endtask

  task automatic seek(input int p);
    while ((bpos + 1) % 64 != p) roll_once();
  endtask

  task automatic wcal(input logic [7:0] d, input bit roll, input int exp, input string tag);
    int n;
    cyc();
    ctl_wr = 1'b1; ctl_din = d;
    cyc();
    if (roll) begin minute_roll = 1'b1; bpos = (bpos + 1) % 64; end
    meas(n);
    chk(n == exp, tag, n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int n, tgl;
    logic hold, prev;
    rst_n = 1'b0; osc_tick = 1'b0; osc_off = 1'b0; sec_wr = 1'b0;
    ctl_wr = 1'b0; ctl_din = 8'h00; minute_roll = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ft_pin == 1'b1, "R1 pin after reset", int'(ft_pin), 1);
    chk(sec_tick == 1'b0, "R1 sec_tick after reset", int'(sec_tick), 0);
    chk(tap512 == 1'b0, "R1 tap after reset", int'(tap512), 0);
    rst_n = 1'b1; osc_tick = 1'b1;

    // R2: uncorrected seconds
    meas(n); chk(n == P, "R2 first second", n, P);
    meas(n); chk(n == P, "R2 second gap", n, P);
    sparse = 1'b1;
    meas(n);
    meas(n); chk(n == 2 * P, "R2 sparse ticks gap", n, 2 * P);
    sparse = 1'b0;
    meas(n);

    // R3: oscillator off
    cyc(); osc_off = 1'b1;
    cyc(); hold = tap512;
    for (int i = 0; i < 3 * P / 2; i++) begin
      cyc();
      if (sec_tick !== 1'b0 || tap512 !== hold) chk(1'b0, "R3 frozen", int'(tap512), int'(hold));
    end
    chk(tap512 == hold, "R3 tap held", int'(tap512), int'(hold));
    osc_off = 1'b0;

    // R4: seconds write clears chain
    cyc(); sec_wr = 1'b1;
    cyc();
    meas(n); chk(n == P, "R4 after seconds write", n, P);

    // R10 / R9: output-level bit
    cyc(); ctl_wr = 1'b1; ctl_din = 8'h00;
    cyc(); chk(ft_pin == 1'b0, "R10 R9 out bit 0", int'(ft_pin), 0);
    wcal(8'h80, 1'b0, P, "R4 after control write");
    chk(ft_pin == 1'b1, "R10 R9 out bit 1", int'(ft_pin), 1);

    // R6, R5, R7, R11
    seek(1); wcal(8'h01, 1'b1, P + BLK, "R6 blank pos1 N1");
    seek(2); wcal(8'h01, 1'b1, P, "R5 pos2 at 2N uncorrected");
    seek(3); wcal(8'h22, 1'b1, P - INS, "R7 insert pos3 N2");
    seek(4); wcal(8'h00, 1'b1, P, "R11 N0 uncorrected");
    seek(61); wcal(8'h1F, 1'b1, P + BLK, "R11 N31 pos61 corrected");
    seek(62); wcal(8'h1F, 1'b1, P, "R11 N31 pos62 uncorrected");
    seek(63); wcal(8'h1F, 1'b1, P, "R11 N31 pos63 uncorrected");
    seek(0);  wcal(8'h3F, 1'b1, P - INS, "R5 wrap to pos0 corrected");

    // R8 / R9: tap rate unchanged during insertion
    seek(1);
    cyc(); ctl_wr = 1'b1; ctl_din = 8'h7F;
    cyc(); minute_roll = 1'b1; bpos = (bpos + 1) % 64;
    prev = ft_pin; tgl = 0;
    for (int i = 2; i <= 40; i++) begin
      cyc();
      if (ft_pin != prev) tgl++;
      prev = ft_pin;
    end
    chk(tgl == 39 / TAPN, "R8 R9 tap toggles during insert", tgl, 39 / TAPN);
    meas(n);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule